// File: doc/BRIEF.md
# UART Receive Queue with Inactivity Timeout

This block is the receive buffering path of a high-speed serial port. A receiver deserializer hands it one character at a time on `rx_valid`. Each character carries a framing-error flag and a break flag. The block stores the characters in order in a 64-entry queue. The oldest entry is always visible on a 32-bit read word. A read strobe removes that entry. When the queue is empty, the word says so, so software can keep reading until it sees the empty flag.

The block reports the fill level at all times. It raises a level-sensitive trigger request while the fill level is at or above a selectable threshold. A small state machine measures line inactivity in character times, using a bit-tick input and 10 ticks per character. It raises a timeout request when the line stays quiet for the selected time while characters are still waiting. The timer has three states:
- `TMO_IDLE`: the queue is empty or the timeout is disabled.
- `TMO_COUNT`: the timer is counting bit ticks.
- `TMO_FIRED`: the request is raised.

The timer moves between these states as follows:
- From `TMO_IDLE` to `TMO_COUNT` once data is held and the timeout is enabled.
- From `TMO_COUNT` to `TMO_FIRED` on the tick that completes the window.
- From `TMO_COUNT` or `TMO_FIRED` back to `TMO_COUNT` with a cleared count on any push or read strobe.
- From any state to `TMO_IDLE` when the queue is empty or the timeout is disabled.

If a character arrives while the queue is full, it is dropped and a sticky overrun flag is set.

Top module: `uart_rx_queue`

## Requirements
- R1: `rd_word` shows the oldest stored character. Bits 7:0 hold its data, bit 9 its framing-error flag and bit 10 its break flag. Bit 8 and bits 31:11 read as zero.
- R2: While the queue is empty, `rd_word` equals 0x100 (bit 8 set, all other bits zero). A `rd_pop` in that state changes no output.
- R3: `fill_level` equals the number of stored entries (0 to 64). It changes on the clock edge that accepts a push or pop. Characters come out in arrival order.
- R4: The 3-bit `trig_sel` codes 0 to 5 select thresholds of 1, 4, 8, 16, 32 and 48 characters. Codes 6 and 7 also select 48. `trig_req` is high exactly while `fill_level` is at or above the threshold.
- R5: `trig_req` falls in the same cycle that `fill_level` drops below the threshold after a pop.
- R6: The 2-bit `tmo_sel` codes select the timeout: 0 disables it, and 1, 2 and 3 select 4, 8 and 16 character times of 10 `bit_tick` pulses each. Starting from an idle queue that just received data, `tmo_req` rises once that many ticks have been counted with no push or read.
- R7: Any `rx_valid` or `rd_pop` restarts the inactivity count and clears `tmo_req` at that edge. `tmo_req` also stays low while the queue is empty.
- R8: A push while the queue holds 64 entries, with no pop in the same cycle, discards the character and leaves the contents and `fill_level` unchanged. It sets `overrun`.
- R9: `overrun` stays set until `ovr_clr`. If a new overflow happens in the same cycle as `ovr_clr`, the set wins.
- R10: A push together with a pop on a full queue is accepted: the oldest entry leaves, the new one enters, and `overrun` is not set.
- R11: After reset the queue is empty, `fill_level` is 0, and `trig_req`, `tmo_req` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Character present from deserializer |
| rx_data | input | 8 | Received character |
| rx_frame_err | input | 1 | Character had a framing error |
| rx_break | input | 1 | Character is a break |
| rd_pop | input | 1 | Read strobe; pops the oldest entry if any |
| rd_word | output | 32 | Tagged read word for the oldest entry |
| fill_level | output | 8 | Number of stored entries |
| trig_sel | input | 3 | Trigger threshold code |
| tmo_sel | input | 2 | Inactivity timeout code |
| bit_tick | input | 1 | One pulse per bit period |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| trig_req | output | 1 | Fill level at or above threshold |
| tmo_req | output | 1 | Inactivity timeout with data waiting |
| overrun | output | 1 | Sticky overflow event |

## Verification
The queue is exercised with several traffic patterns:
- Short bursts of characters with mixed error and break flags, which separate bit placement faults from ordering faults.
- Reads of an empty queue, which show whether an empty pop corrupts the pointers.
- A fill to capacity followed by an extra push and by a simultaneous push and pop, which distinguishes a correct drop from an overwrite and a correct exchange from a false overrun.
- Sweeps of the trigger code over a filling and draining queue, which expose off-by-one threshold comparisons.
- Idle stretches under each timeout code, with dense and sparse ticks and with activity part-way through, which separate an early or late firing from a missed restart.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic [7:0] data;
    } rxq_entry_t;

    typedef enum logic [1:0] {
        TMO_IDLE  = 2'd0,
        TMO_COUNT = 2'd1,
        TMO_FIRED = 2'd2
    } tmo_state_t;

    // threshold in characters for each trigger code
    function automatic int trig_chars(input logic [2:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 4;
            3'd2:    return 8;
            3'd3:    return 16;
            3'd4:    return 32;
            default: return 48;
        endcase
    endfunction

    // inactivity window in character times for each timeout code
    function automatic int tmo_chars(input logic [1:0] code);
        case (code)
            2'd1:    return 4;
            2'd2:    return 8;
            2'd3:    return 16;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  rxq_entry_t       wr_entry,
    input  logic             rd_en,
    output rxq_entry_t       head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             ovf
);
    rxq_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             full;
    logic             pop_ok;
    logic             push_ok;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign pop_ok  = rd_en && !empty;
    assign push_ok = wr_en && (!full || pop_ok);
    assign ovf     = wr_en && full && !pop_ok;
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wr_entry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
        end
    end

    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> $stable(count));

    // R2
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !wr_en) |=> (count == '0));

endmodule

// File: rtl/rxq_trigger.sv
module rxq_trigger
    import uart_rxq_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [2:0]       sel,
    output logic             req
);
    int thr;

    always_comb begin
        thr = trig_chars(sel);
        req = (int'(count) >= thr);
    end

    // R4
    trig_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !req);

endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer
    import uart_rxq_pkg::*;
#(
    parameter int BITS_PER_CHAR = 10,
    localparam int MAX_TICKS = 16 * BITS_PER_CHAR,
    localparam int TCNT_W = $clog2(MAX_TICKS)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       bit_tick,
    input  logic       activity,
    input  logic       q_empty,
    output logic       req
);
    tmo_state_t        state, state_nxt;
    logic [TCNT_W-1:0] tcnt, tcnt_nxt;
    logic [TCNT_W-1:0] last_tick;
    logic              enabled;

    assign enabled   = (sel != 2'd0);
    assign last_tick = TCNT_W'(tmo_chars(sel) * BITS_PER_CHAR - 1);

    always_comb begin
        state_nxt = state;
        tcnt_nxt  = tcnt;
        if (!enabled || q_empty) begin
            state_nxt = TMO_IDLE;
            tcnt_nxt  = '0;
        end else if (activity) begin
            state_nxt = TMO_COUNT;
            tcnt_nxt  = '0;
        end else begin
            unique case (state)
                TMO_IDLE: begin
                    state_nxt = TMO_COUNT;
                    tcnt_nxt  = '0;
                end
                TMO_COUNT: begin
                    if (bit_tick) begin
                        if (tcnt == last_tick) begin
                            state_nxt = TMO_FIRED;
                            tcnt_nxt  = '0;
                        end else begin
                            tcnt_nxt = tcnt + 1'b1;
                        end
                    end
                end
                TMO_FIRED: begin
                    state_nxt = TMO_FIRED;
                end
                default: begin
                    state_nxt = TMO_IDLE;
                    tcnt_nxt  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TMO_IDLE;
            tcnt  <= '0;
        end else begin
            state <= state_nxt;
            tcnt  <= tcnt_nxt;
        end
    end

    always_comb begin
        req = (state == TMO_FIRED);
    end

    // R7
    tmo_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> !req);

    // R6
    tmo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'd0) |=> !req);

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH         = 64,
    parameter int LVL_W         = 8,
    parameter int WORD_W        = 32,
    parameter int BITS_PER_CHAR = 10,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_frame_err,
    input  logic              rx_break,
    input  logic              rd_pop,
    output logic [WORD_W-1:0] rd_word,
    output logic [LVL_W-1:0]  fill_level,
    input  logic [2:0]        trig_sel,
    input  logic [1:0]        tmo_sel,
    input  logic              bit_tick,
    input  logic              ovr_clr,
    output logic              trig_req,
    output logic              tmo_req,
    output logic              overrun
);
    rxq_entry_t       in_entry;
    rxq_entry_t       head;
    logic [CNT_W-1:0] count;
    logic             q_empty;
    logic             ovf;

    assign in_entry = '{brk: rx_break, ferr: rx_frame_err, data: rx_data};

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rx_valid),
        .wr_entry (in_entry),
        .rd_en    (rd_pop),
        .head     (head),
        .count    (count),
        .empty    (q_empty),
        .ovf      (ovf)
    );

    rxq_trigger #(.CNT_W(CNT_W)) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .count (count),
        .sel   (trig_sel),
        .req   (trig_req)
    );

    rxq_idle_timer #(.BITS_PER_CHAR(BITS_PER_CHAR)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (tmo_sel),
        .bit_tick (bit_tick),
        .activity (rx_valid || rd_pop),
        .q_empty  (q_empty),
        .req      (tmo_req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       overrun <= 1'b0;
        else if (ovf)     overrun <= 1'b1;
        else if (ovr_clr) overrun <= 1'b0;
    end

    always_comb begin
        rd_word = '0;
        if (q_empty) begin
            rd_word[8] = 1'b1;
        end else begin
            rd_word[7:0] = head.data;
            rd_word[9]   = head.ferr;
            rd_word[10]  = head.brk;
        end
    end

    assign fill_level = LVL_W'(count);

    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);

    // R3
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level <= LVL_W'(DEPTH)));

endmodule

// File: tb/uart_rx_queue_bench.sv
module uart_rx_queue_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_frame_err = 1'b0;
    logic        rx_break = 1'b0;
    logic        rd_pop = 1'b0;
    logic [31:0] rd_word;
    logic [7:0]  fill_level;
    logic [2:0]  trig_sel = 3'd0;
    logic [1:0]  tmo_sel = 2'd0;
    logic        bit_tick = 1'b0;
    logic        ovr_clr = 1'b0;
    logic        trig_req, tmo_req, overrun;

    int tests = 0;
    int fails = 0;

    // behavioural reference state
    logic [9:0] mq[$];
    int  m_st = 0;
    int  m_cnt = 0;
    bit  m_ovr = 0;

    always #2 clk = ~clk;

    uart_rx_queue u_uart_rx_queue (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_frame_err(rx_frame_err), .rx_break(rx_break), .rd_pop(rd_pop),
        .rd_word(rd_word), .fill_level(fill_level), .trig_sel(trig_sel),
        .tmo_sel(tmo_sel), .bit_tick(bit_tick), .ovr_clr(ovr_clr),
        .trig_req(trig_req), .tmo_req(tmo_req), .overrun(overrun)
    );

    function automatic int thr_of(input logic [2:0] c);
        int t;
        case (c)
            3'd0: t = 1;  3'd1: t = 4;  3'd2: t = 8;
            3'd3: t = 16; 3'd4: t = 32; default: t = 48;
        endcase
        return t;
    endfunction

    function automatic int ticks_of(input logic [1:0] c);
        return (c == 2'd1) ? 40 : (c == 2'd2) ? 80 : (c == 2'd3) ? 160 : 0;
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [31:0] ew;
        if (mq.size() == 0) ew = 32'h100;
        else ew = {21'd0, mq[0][9], mq[0][8], 1'b0, mq[0][7:0]};
        chk("R1/R2", "rd_word", rd_word, ew);
        chk("R3", "fill_level", fill_level, mq.size());
        chk("R4/R5", "trig_req", trig_req, (mq.size() >= thr_of(trig_sel)));
        chk("R6/R7", "tmo_req", tmo_req, (m_st == 2));
        chk("R8/R9", "overrun", overrun, m_ovr);
    endtask

    task automatic step(input bit v, input logic [7:0] d, input bit e, input bit b,
                        input bit pop, input bit tick, input bit clr);
        int  sz;
        bit  pop_ok, push_ok, ovf, act;
        rx_valid = v; rx_data = d; rx_frame_err = e; rx_break = b;
        rd_pop = pop; bit_tick = tick; ovr_clr = clr;
        sz      = mq.size();
        pop_ok  = pop && (sz > 0);
        push_ok = v && ((sz < 64) || pop_ok);
        ovf     = v && (sz == 64) && !pop_ok;
        act     = v || pop;
        if (tmo_sel == 2'd0 || sz == 0) begin
            m_st = 0; m_cnt = 0;
        end else if (act) begin
            m_st = 1; m_cnt = 0;
        end else if (m_st == 0) begin
            m_st = 1; m_cnt = 0;
        end else if (m_st == 1 && tick) begin
            if (m_cnt == ticks_of(tmo_sel) - 1) begin m_st = 2; m_cnt = 0; end
            else m_cnt++;
        end
        if (pop_ok)  void'(mq.pop_front());
        if (push_ok) mq.push_back({b, e, d});
        if (ovf) m_ovr = 1;
        else if (clr) m_ovr = 0;
        @(posedge clk);
        @(negedge clk);
        rx_valid = 0; rd_pop = 0; bit_tick = 0; ovr_clr = 0;
        compare_all();
    endtask

    task automatic push(input logic [7:0] d, input bit e, input bit b);
        step(1, d, e, b, 0, 0, 0);
    endtask

    task automatic pop1();
        step(0, 8'h00, 0, 0, 1, 0, 0);
    endtask

    task automatic idle(input int n, input int tick_every);
        for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, (i % tick_every) == 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11", "reset fill_level", fill_level, 0);
        chk("R11", "reset rd_word", rd_word, 32'h100);
        chk("R11", "reset flags", {trig_req, tmo_req, overrun}, 0);
        compare_all();

        // R1 field placement, R2 empty reads
        trig_sel = 3'd1;
        push(8'hA5, 0, 0);
        push(8'h3C, 1, 0);
        push(8'h00, 0, 1);
        chk("R1", "head word", rd_word, 32'h0A5);
        pop1();
        chk("R1", "ferr word", rd_word, 32'h23C);
        pop1();
        chk("R1", "break word", rd_word, 32'h400);
        pop1();
        pop1();
        pop1();
        chk("R2", "empty after extra pops", rd_word, 32'h100);
        push(8'h11, 0, 0);
        chk("R2", "push after empty pops", rd_word, 32'h011);
        pop1();

        // R4 R5: fill to capacity, sweeping trigger codes
        for (int i = 0; i < 64; i++) begin
            trig_sel = 3'(i % 8);
            push(8'(i), i[0], i[1]);
        end
        chk("R3", "full level", fill_level, 64);
        // R8: overflow discards, sticky flag
        push(8'hEE, 1, 1);
        chk("R8", "overflow level", fill_level, 64);
        chk("R8", "overflow flag", overrun, 1);
        idle(3, 1);
        chk("R9", "overrun sticky", overrun, 1);
        // R9: set wins over clear
        step(1, 8'hEF, 0, 0, 0, 0, 1);
        chk("R9", "set beats clear", overrun, 1);
        step(0, 8'h00, 0, 0, 0, 0, 1);
        chk("R9", "cleared", overrun, 0);
        // R10: exchange on full
        step(1, 8'h77, 0, 0, 1, 0, 0);
        chk("R10", "exchange level", fill_level, 64);
        chk("R10", "no overrun on exchange", overrun, 0);
        // drain with trigger codes sweeping: R3 order, R5 falling
        for (int i = 0; i < 64; i++) begin
            trig_sel = 3'((i / 5) % 8);
            pop1();
        end
        chk("R3", "drained", fill_level, 0);

        // R6 timeout code 1, dense ticks
        tmo_sel = 2'd1;
        trig_sel = 3'd5;
        push(8'h42, 0, 0);
        idle(30, 1);
        chk("R6", "tmo not early", tmo_req, 0);
        idle(15, 1);
        chk("R6", "tmo fired", tmo_req, 1);
        // R7 activity clears and restarts
        push(8'h43, 0, 0);
        chk("R7", "tmo cleared by push", tmo_req, 0);
        idle(60, 1);
        pop1();
        chk("R7", "tmo cleared by read", tmo_req, 0);
        idle(20, 1);
        pop1();
        idle(60, 1);
        chk("R7", "no tmo when empty", tmo_req, 0);

        // R6 code 2 with sparse ticks, code 3, and disabled
        tmo_sel = 2'd2;
        push(8'h50, 1, 0);
        idle(400, 4);
        chk("R6", "tmo code2 fired", tmo_req, 1);
        tmo_sel = 2'd3;
        pop1();
        push(8'h51, 0, 1);
        idle(170, 1);
        chk("R6", "tmo code3 fired", tmo_req, 1);
        tmo_sel = 2'd0;
        idle(200, 1);
        chk("R6", "tmo disabled", tmo_req, 0);
        pop1();
        pop1();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule